// File: doc/BRIEF.md
# Receive Slot Resizer and Packer

This block sits between the frame decoder of a serial audio link and the CPU side of one receive channel. Each frame, the decoder offers 20-bit slot words tagged with their slot number. The block keeps only the slots enabled in the channel's slot mask. It shifts each kept word right so that the sample is LSB-justified to the programmed sample size, and it writes the result into an 8-entry FIFO.

On the CPU side, each read returns a 32-bit word. In normal mode a read holds one sample. In compact mode, which takes effect only at 12- or 16-bit sizes, a read joins two FIFO entries into one word, with the older entry in the low half.

The block drives three status outputs:
- a DMA request, which in compact mode needs two entries to be present;
- a sticky overrun flag for slot words lost to a full FIFO;
- a timeout interrupt, raised when data has sat unread for a programmed number of frames.

Top module: `rx_slot_packer`

## Requirements
- R1: The FIFO holds up to DEPTH (8) samples. `level` reports the current count. A slot word that passes the mask is written when `level` is below DEPTH.
- R2: A slot word offered with `slot_valid` is kept only if bit `slot_num` of `slot_mask` is 1. Any other slot word is dropped and leaves `level` and the FIFO contents unchanged.
- R3: `size_sel` picks the sample size: 00 = 12 bits (shift right by 8), 01 = 16 bits (shift right by 4), 10 = 18 bits (shift right by 2), 11 = 20 bits (no shift). The vacated upper bits of the 20-bit entry are zero.
- R4: In normal mode, a read of a non-empty FIFO returns the oldest entry in bits 19:0, with bits 31:20 zero, and removes that one entry.
- R5: Compact mode is active when `compact` is 1 and `size_sel` is 00 or 01; with `size_sel` 10 or 11 the block acts as in R4.
  - With two or more entries, a compact read returns bits 15:0 of the oldest entry in bits 15:0 and bits 15:0 of the next entry in bits 31:16, and removes both entries.
  - With one entry, a compact read returns that entry in bits 15:0, with bits 31:16 zero, and removes it.
- R6: `dma_req` is 1 when `level` is at least 1 in normal mode, and when `level` is at least 2 in compact mode.
- R7: A slot word that passes the mask while `level` equals DEPTH is dropped and sets `overrun`. `overrun` stays set until `ovr_clr` is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R8: A frame counter advances on each `frame_tick` while the FIFO is non-empty. It returns to zero on every accepted write, on every read of a non-empty FIFO, and whenever the FIFO is empty. `timeout_irq` is 1 when `timeout` is non-zero, the FIFO is non-empty, and the counter has reached `timeout`.
- R9: A read of an empty FIFO returns zero and changes neither `level` nor any stored entry.
- R10: When a read and a slot write fall in the same cycle, the full check for the write uses `level` from before the read. A write to a full FIFO is therefore dropped and flagged as an overrun even when a read takes place in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_valid | input | 1 | A slot word is offered this cycle |
| slot_num | input | 4 | Slot number of the offered word |
| slot_data | input | 20 | Raw slot word from the frame decoder |
| frame_tick | input | 1 | One-cycle pulse per received frame |
| slot_mask | input | 16 | Receive slot enables; bit n enables slot n |
| size_sel | input | 2 | Sample size code (R3) |
| compact | input | 1 | Request for two samples per read word |
| timeout | input | 8 | Timeout period in frames; 0 disables |
| rd_en | input | 1 | CPU read strobe; `rd_data` is valid in the same cycle |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| rd_data | output | 32 | Read word |
| level | output | 4 | Number of stored samples |
| dma_req | output | 1 | Receive DMA request |
| overrun | output | 1 | Sticky overrun flag |
| timeout_irq | output | 1 | Receive timeout interrupt |

## Verification
The assertions check on every cycle that the fill count never exceeds the depth. They also check that a masked-out slot leaves the count unchanged, that an empty read returns zero, and that a write to a full FIFO always raises the overrun flag, which then holds until cleared. Two further checks run on every cycle: in compact mode a single stored entry never raises the DMA request, and an empty FIFO never signals a timeout. The exact resized values, the ordering of samples in the halves of a compact read, the behaviour of a compact read with one entry, and the frame count at which the timeout fires are shown only by the bench's scenarios, where a reference model is compared against the outputs on every cycle.

// File: rtl/rx_slot_packer.sv
module rx_slot_packer #(
  parameter int DEPTH = 8,
  parameter int SW    = 20,
  parameter int DW    = 32,
  parameter int NSLOT = 16,
  parameter int TW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     slot_valid,
  input  logic [$clog2(NSLOT)-1:0] slot_num,
  input  logic [SW-1:0]            slot_data,
  input  logic                     frame_tick,
  input  logic [NSLOT-1:0]         slot_mask,
  input  logic [1:0]               size_sel,
  input  logic                     compact,
  input  logic [TW-1:0]            timeout,
  input  logic                     rd_en,
  input  logic                     ovr_clr,
  output logic [DW-1:0]            rd_data,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                     dma_req,
  output logic                     overrun,
  output logic                     timeout_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int HW = DW / 2;

  logic [SW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp, rp1;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tcnt;
  logic [SW-1:0] sized, head0, head1;
  logic          compact_eff, slot_hit, wr_acc, rd_act, has_two, empty;
  logic [1:0]    pop_n;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign compact_eff = compact & ~size_sel[1];
  assign empty       = (cnt == '0);
  assign has_two     = (cnt >= CW'(2));
  assign slot_hit    = slot_valid & slot_mask[slot_num];
  assign wr_acc      = slot_hit & (cnt != CW'(DEPTH));
  assign rd_act      = rd_en & ~empty;
  assign pop_n       = !rd_act ? 2'd0 : (compact_eff && has_two) ? 2'd2 : 2'd1;
  assign rp1         = inc(rp);
  assign head0       = mem[rp];
  assign head1       = mem[rp1];

  always_comb begin
    case (size_sel)
      2'b00:   sized = slot_data >> 8;
      2'b01:   sized = slot_data >> 4;
      2'b10:   sized = slot_data >> 2;
      default: sized = slot_data;
    endcase
  end

  always_comb begin
    if (empty)
      rd_data = '0;
    else if (compact_eff)
      rd_data = {(has_two ? head1[HW-1:0] : {HW{1'b0}}), head0[HW-1:0]};
    else
      rd_data = {{(DW-SW){1'b0}}, head0};
  end

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wp] <= sized;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      overrun <= 1'b0;
      tcnt    <= '0;
    end else begin
      if (wr_acc) wp <= inc(wp);
      if (pop_n == 2'd1) rp <= rp1;
      else if (pop_n == 2'd2) rp <= inc(rp1);
      cnt <= cnt + CW'(wr_acc) - CW'(pop_n);
      if (slot_hit && !wr_acc) overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
      if (wr_acc || rd_act || empty) tcnt <= '0;
      else if (frame_tick && tcnt != {TW{1'b1}}) tcnt <= tcnt + 1'b1;
    end
  end

  assign level       = cnt;
  assign dma_req     = compact_eff ? has_two : ~empty;
  assign timeout_irq = (timeout != '0) && !empty && (tcnt >= timeout);

  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  assert_drop_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && !slot_mask[slot_num] && !rd_en) |=> $stable(level));
  assert_dma_compact_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (compact && !size_sel[1] && level == CW'(1)) |-> !dma_req);
  assert_overrun_on_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && slot_mask[slot_num] && level == CW'(DEPTH)) |=> overrun);
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);
  assert_no_timeout_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> !timeout_irq);
  assert_empty_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && level == '0) |-> (rd_data == '0));
endmodule

// File: tb/sim_rx_slot_packer.sv
module sim_rx_slot_packer;
  logic clk = 0, rst_n = 0;
  logic slot_valid = 0, frame_tick = 0, compact = 0, rd_en = 0, ovr_clr = 0;
  logic [3:0]  slot_num = 0;
  logic [19:0] slot_data = 0;
  logic [15:0] slot_mask = 16'h0078;
  logic [1:0]  size_sel = 2'b11;
  logic [7:0]  timeout = 0;
  logic [31:0] rd_data;
  logic [3:0]  level;
  logic dma_req, overrun, timeout_irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [19:0] q[$];
  bit m_ovr = 0;
  int m_tc = 0;
  logic [31:0] last_rd;

  always #5 clk = ~clk;

  rx_slot_packer u0 (.clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_num(slot_num),
    .slot_data(slot_data), .frame_tick(frame_tick), .slot_mask(slot_mask), .size_sel(size_sel),
    .compact(compact), .timeout(timeout), .rd_en(rd_en), .ovr_clr(ovr_clr), .rd_data(rd_data),
    .level(level), .dma_req(dma_req), .overrun(overrun), .timeout_irq(timeout_irq));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [19:0] rsz(input logic [19:0] d, input logic [1:0] s);
    case (s)
      2'b00: return d >> 8;
      2'b01: return d >> 4;
      2'b10: return d >> 2;
      default: return d;
    endcase
  endfunction

  task automatic cyc();
    bit ce, hit, acc, rda;
    int n;
    logic [31:0] er;
    #1;
    ce = compact && (size_sel == 2'b00 || size_sel == 2'b01);
    if (q.size() == 0) er = 0;
    else if (ce) er = {(q.size() >= 2 ? q[1][15:0] : 16'h0), q[0][15:0]};
    else er = {12'h0, q[0]};
    last_rd = rd_data;
    if (rd_en) chk(rd_data === er, q.size() == 0 ? "R9" : (ce ? "R5" : "R4"), rd_data, er);
    chk(level === 4'(q.size()), "R1", 32'(level), 32'(q.size()));
    chk(dma_req === (ce ? q.size() >= 2 : q.size() >= 1), "R6", 32'(dma_req), 32'(ce ? q.size() >= 2 : q.size() >= 1));
    chk(overrun === m_ovr, "R7", 32'(overrun), 32'(m_ovr));
    chk(timeout_irq === (timeout != 0 && q.size() > 0 && m_tc >= timeout), "R8", 32'(timeout_irq), 32'(m_tc));
    hit = slot_valid && slot_mask[slot_num];
    acc = hit && q.size() < 8;
    rda = rd_en && q.size() > 0;
    n = rda ? ((ce && q.size() >= 2) ? 2 : 1) : 0;
    if (acc || rda || q.size() == 0) m_tc = 0;
    else if (frame_tick && m_tc < 255) m_tc++;
    if (hit && !acc) m_ovr = 1; else if (ovr_clr) m_ovr = 0;
    for (int i = 0; i < n; i++) void'(q.pop_front());
    if (acc) q.push_back(rsz(slot_data, size_sel));
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [3:0] s, input logic [19:0] d);
    slot_valid = 1; slot_num = s; slot_data = d; cyc(); slot_valid = 0;
  endtask
  task automatic rd();
    rd_en = 1; cyc(); rd_en = 0;
  endtask
  task automatic tick();
    frame_tick = 1; cyc(); frame_tick = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk(level == 0 && !dma_req && !overrun && !timeout_irq, "R1", 32'(level), 0);
    rst_n = 1;
    @(negedge clk);
    // R2 / R4 : full width, masked slots only
    push(3, 20'hABCDE); push(7, 20'h11111); push(1, 20'h22222);
    chk(level == 1, "R2", 32'(level), 1);
    push(4, 20'h12345);
    rd(); chk(last_rd == 32'h000ABCDE, "R4", last_rd, 32'h000ABCDE);
    rd(); chk(last_rd == 32'h00012345, "R4", last_rd, 32'h00012345);
    rd(); chk(last_rd == 0 && level == 0, "R9", last_rd, 0);
    // R3 : each size
    size_sel = 2'b00; push(3, 20'hABCDE); rd(); chk(last_rd == 32'h00000ABC, "R3", last_rd, 32'h00000ABC);
    size_sel = 2'b01; push(3, 20'hABCDE); rd(); chk(last_rd == 32'h0000ABCD, "R3", last_rd, 32'h0000ABCD);
    size_sel = 2'b10; push(3, 20'hFFFFF); rd(); chk(last_rd == 32'h0003FFFF, "R3", last_rd, 32'h0003FFFF);
    // R7 / R10 : fill and overflow
    size_sel = 2'b11;
    for (int i = 0; i < 8; i++) push(4'(3 + i % 4), 20'(i + 1));
    push(5, 20'h99999);
    chk(overrun && level == 8, "R7", 32'(overrun), 1);
    ovr_clr = 1; cyc(); ovr_clr = 0;
    chk(!overrun, "R7", 32'(overrun), 0);
    rd_en = 1; slot_valid = 1; slot_num = 6; slot_data = 20'h55555; cyc();
    rd_en = 0; slot_valid = 0;
    chk(level == 7 && overrun, "R10", 32'(level), 7);
    ovr_clr = 1; cyc(); ovr_clr = 0;
    for (int i = 0; i < 8; i++) rd();
    // R5 : compact, 16 bits
    size_sel = 2'b01; compact = 1;
    push(3, 20'h1234F); push(4, 20'h5678F); push(5, 20'h9ABCF);
    chk(dma_req, "R6", 32'(dma_req), 1);
    rd(); chk(last_rd == 32'h56781234, "R5", last_rd, 32'h56781234);
    chk(!dma_req && level == 1, "R6", 32'(dma_req), 0);
    rd(); chk(last_rd == 32'h00009ABC, "R5", last_rd, 32'h00009ABC);
    // compact requested at 18 bits behaves as normal mode
    size_sel = 2'b10; push(3, 20'h00004); push(4, 20'h00008);
    rd(); chk(last_rd == 32'h00000001 && level == 1, "R5", last_rd, 32'h1);
    rd(); compact = 0; size_sel = 2'b11;
    // R8 : timeout
    timeout = 3; push(3, 20'h00001);
    tick(); tick(); chk(!timeout_irq, "R8", 32'(timeout_irq), 0);
    tick(); chk(timeout_irq, "R8", 32'(timeout_irq), 1);
    push(4, 20'h00002); chk(!timeout_irq, "R8", 32'(timeout_irq), 0);
    tick(); tick(); tick(); chk(timeout_irq, "R8", 32'(timeout_irq), 1);
    rd(); chk(!timeout_irq, "R8", 32'(timeout_irq), 0);
    rd(); tick(); tick(); tick(); tick();
    chk(!timeout_irq && level == 0, "R8", 32'(timeout_irq), 0);
    rd(); chk(last_rd == 0, "R9", last_rd, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule